// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target that looks to a bus controller like a small byte-addressable EEPROM. Behind it sits an internal register array. After a START, the block compares the 7-bit address it receives with a target address supplied on an input port. It then serves write or read transfers and keeps a byte pointer that decides where the next access lands. The first data byte after a write-direction address is taken as the new pointer value and is not stored. Each later byte is stored at the pointer. Read transfers stream bytes out starting at the pointer. Each access moves the pointer forward by one and wraps it modulo the array size.

The bus is seen through two oversampled inputs, one for SCL and one for SDA, each with a two-flop synchronizer. The block pulls SDA low through a single open-drain enable. A side port watches stored writes. When a stored byte lands at an address inside an inclusive window [watch_lo, watch_hi], the block raises a one-cycle strobe carrying that address and the data byte. Logic elsewhere on the chip can use this to react to configuration writes.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, SDA is released (sda_oe = 0), note_stb is low, the byte pointer is 0 and every array byte reads 0.
- R2: An address byte whose upper seven bits equal own_addr is acknowledged. Any other address is not acknowledged, and the block then leaves SDA released and stores nothing until the next START.
- R3: The first data byte after a matching write-direction address (bit 0 = 0) loads the pointer with that byte modulo MEM_BYTES. It is not stored and raises no notification.
- R4: Each further write byte is stored at the pointer, and the pointer then advances by one, wrapping from MEM_BYTES-1 to 0.
- R5: After a matching read-direction address (bit 0 = 1), each byte sent MSB first comes from the pointer location, and the pointer then advances with the same wrap.
- R6: A STOP, or a matching read-direction address, cancels a pending pointer load. The pointer then keeps the value it had before the write-direction address.
- R7: A stored byte at address A with watch_lo <= A <= watch_hi raises note_stb for exactly one clock, with note_addr = A and note_data = the byte. Stored bytes outside the window raise no strobe.
- R8: When the controller NACKs a read byte, the block stops driving SDA until the next START or STOP. A fresh START is then served normally.
- R9: Every data byte received in a matched write transfer is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| own_addr | input | 7 | Target address to answer |
| watch_lo | input | 8 | Inclusive lower bound of the watch window |
| watch_hi | input | 8 | Inclusive upper bound of the watch window |
| note_stb | output | 1 | One-cycle strobe for a stored byte in the window |
| note_addr | output | 8 | Array address of the watched write |
| note_data | output | 8 | Data byte of the watched write |

## Verification
The hardest state to reach from the ports is a pointer load that was armed and then cancelled. Only the absence of a pointer change shows it, and that absence is visible only through a later read. The bench first places the pointer at a known location. It then sends a bare write-direction address and ends it with either a STOP or a repeated START in read direction. A follow-up read must return the byte at the old pointer. The pointer wrap is reached by streaming more bytes than the array holds, in a configuration with a 16-byte array, so that the write and read streams both cross the end of the array.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int TGT_ADDR_W = 7;
   localparam int TGT_BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_END,
      ST_ADDR_ACK,
      ST_WR_DATA,
      ST_WR_END,
      ST_WR_ACK,
      ST_RD_DATA,
      ST_RD_ACK,
      ST_RD_MORE,
      ST_PARK
   } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("i2c_tgt_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
   logic scl_d, sda_d, scl_s;

   assign scl_s = scl_ff[SYNC_STAGES-1];
   assign sda_s = sda_ff[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
         scl_d  <= scl_s;
         sda_d  <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter int MEM_BYTES = 256,
   parameter int PTR_W     = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_rise,
   input  logic                  scl_fall,
   input  logic                  start_det,
   input  logic                  stop_det,
   input  logic                  sda_s,
   input  logic [TGT_ADDR_W-1:0] own_addr,
   input  logic [TGT_BYTE_W-1:0] rd_data,
   output logic [PTR_W-1:0]      ptr,
   output logic                  wr_en,
   output logic [TGT_BYTE_W-1:0] wr_data,
   output logic                  sda_oe
);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(MEM_BYTES - 1);
   localparam bit               POW2     = (MEM_BYTES & (MEM_BYTES - 1)) == 0;

   tgt_state_e            state;
   logic [2:0]            cnt;
   logic [TGT_BYTE_W-1:0] shreg, txsh;
   logic                  pend, is_read;
   logic [PTR_W-1:0]      ptr_next, ptr_load;

   assign ptr_next = (ptr == PTR_LAST) ? '0 : ptr + 1'b1;

   generate
      if (POW2) begin : g_load_pow2
         assign ptr_load = shreg[PTR_W-1:0];
      end else begin : g_load_mod
         assign ptr_load = PTR_W'(32'(shreg) % MEM_BYTES);
      end
   endgenerate

   assign wr_data = shreg;
   assign wr_en   = (state == ST_WR_END) && scl_fall && !pend
                    && !start_det && !stop_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         txsh    <= '0;
         ptr     <= '0;
         pend    <= 1'b0;
         is_read <= 1'b0;
         sda_oe  <= 1'b0;
      end else if (start_det) begin
         state  <= ST_ADDR;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else if (stop_det) begin
         state  <= ST_IDLE;
         pend   <= 1'b0;
         sda_oe <= 1'b0;
      end else begin
         case (state)
            ST_ADDR, ST_WR_DATA: begin
               if (scl_rise) begin
                  shreg <= {shreg[TGT_BYTE_W-2:0], sda_s};
                  if (cnt == 3'd7) begin
                     cnt   <= '0;
                     state <= (state == ST_ADDR) ? ST_ADDR_END : ST_WR_END;
                  end else begin
                     cnt <= cnt + 3'd1;
                  end
               end
            end
            ST_ADDR_END: begin
               if (scl_fall) begin
                  if (shreg[TGT_BYTE_W-1:1] == own_addr) begin
                     sda_oe  <= 1'b1;
                     is_read <= shreg[0];
                     pend    <= ~shreg[0];
                     state   <= ST_ADDR_ACK;
                  end else begin
                     state <= ST_PARK;
                  end
               end
            end
            ST_ADDR_ACK, ST_RD_MORE: begin
               if (scl_fall) begin
                  if (state == ST_RD_MORE || is_read) begin
                     txsh   <= rd_data;
                     sda_oe <= ~rd_data[TGT_BYTE_W-1];
                     ptr    <= ptr_next;
                     cnt    <= '0;
                     state  <= ST_RD_DATA;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_WR_DATA;
                  end
               end
            end
            ST_WR_END: begin
               if (scl_fall) begin
                  sda_oe <= 1'b1;
                  state  <= ST_WR_ACK;
                  if (pend) begin
                     ptr  <= ptr_load;
                     pend <= 1'b0;
                  end else begin
                     ptr <= ptr_next;
                  end
               end
            end
            ST_WR_ACK: begin
               if (scl_fall) begin
                  sda_oe <= 1'b0;
                  state  <= ST_WR_DATA;
               end
            end
            ST_RD_DATA: begin
               if (scl_fall) begin
                  if (cnt == 3'd7) begin
                     cnt    <= '0;
                     sda_oe <= 1'b0;
                     state  <= ST_RD_ACK;
                  end else begin
                     sda_oe <= ~txsh[TGT_BYTE_W-2];
                     txsh   <= {txsh[TGT_BYTE_W-2:0], 1'b0};
                     cnt    <= cnt + 3'd1;
                  end
               end
            end
            ST_RD_ACK: begin
               if (scl_rise) state <= sda_s ? ST_PARK : ST_RD_MORE;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_tgt_store.sv
module i2c_tgt_store
   import i2c_tgt_pkg::*;
#(
   parameter int MEM_BYTES = 256,
   parameter int PTR_W     = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [PTR_W-1:0]      addr,
   input  logic [TGT_BYTE_W-1:0] wr_data,
   input  logic [TGT_BYTE_W-1:0] watch_lo,
   input  logic [TGT_BYTE_W-1:0] watch_hi,
   output logic [TGT_BYTE_W-1:0] rd_data,
   output logic                  note_stb,
   output logic [TGT_BYTE_W-1:0] note_addr,
   output logic [TGT_BYTE_W-1:0] note_data
);
   logic [TGT_BYTE_W-1:0] mem [MEM_BYTES];
   logic [TGT_BYTE_W-1:0] addr_ext;
   logic                  in_win;

   assign addr_ext = TGT_BYTE_W'(addr);
   assign in_win   = (addr_ext >= watch_lo) && (addr_ext <= watch_hi);
   assign rd_data  = mem[addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[addr] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         note_stb  <= 1'b0;
         note_addr <= '0;
         note_data <= '0;
      end else begin
         note_stb <= wr_en && in_win;
         if (wr_en && in_win) begin
            note_addr <= addr_ext;
            note_data <= wr_data;
         end
      end
   end
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
   import i2c_tgt_pkg::*;
#(
   parameter int MEM_BYTES   = 256,
   parameter int SYNC_STAGES = 2,
   localparam int PTR_W      = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [6:0] own_addr,
   input  logic [7:0] watch_lo,
   input  logic [7:0] watch_hi,
   output logic       note_stb,
   output logic [7:0] note_addr,
   output logic [7:0] note_data
);
   generate
      if (MEM_BYTES < 2 || MEM_BYTES > 256) begin : g_bad_size
         $error("i2c_regfile_target: MEM_BYTES must lie in 2..256");
      end
   endgenerate

   logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic             wr_en;
   logic [PTR_W-1:0] ptr;
   logic [7:0]       wr_data, rd_data;

   i2c_tgt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2c_tgt_engine #(.MEM_BYTES(MEM_BYTES), .PTR_W(PTR_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
      .own_addr(own_addr), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
      .wr_data(wr_data), .sda_oe(sda_oe)
   );

   i2c_tgt_store #(.MEM_BYTES(MEM_BYTES), .PTR_W(PTR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(ptr), .wr_data(wr_data),
      .watch_lo(watch_lo), .watch_hi(watch_hi), .rd_data(rd_data),
      .note_stb(note_stb), .note_addr(note_addr), .note_data(note_data)
   );
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker #(
   parameter int MEM_BYTES = 256,
   parameter int PTR_W     = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sda_oe,
   input logic             scl_fall,
   input logic             start_det,
   input logic             stop_det,
   input logic             wr_en,
   input logic [PTR_W-1:0] ptr,
   input logic             note_stb,
   input logic [7:0]       note_addr,
   input logic [7:0]       watch_lo,
   input logic [7:0]       watch_hi
);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(MEM_BYTES - 1);

   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det)); // R2

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe); // R8

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ptr == (($past(ptr) == PTR_LAST) ? '0 : $past(ptr) + 1'b1)); // R4

   AST_ONE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en); // R4

   AST_NOTE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      note_stb |=> !note_stb); // R7

   AST_NOTE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      note_stb |-> (note_addr >= $past(watch_lo)) && (note_addr <= $past(watch_hi))); // R7

   AST_NOTE_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      note_stb |-> $past(wr_en)); // R7
endmodule

bind i2c_regfile_target i2c_tgt_checker #(.MEM_BYTES(MEM_BYTES), .PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_fall(scl_fall),
   .start_det(start_det), .stop_det(stop_det), .wr_en(wr_en), .ptr(ptr),
   .note_stb(note_stb), .note_addr(note_addr), .watch_lo(watch_lo),
   .watch_hi(watch_hi)
);

// File: tb/tb_i2c_regfile_target.sv
module tb_i2c_regfile_target;
   localparam int        MB  = 16;
   localparam int        Q   = 8;
   localparam logic [6:0] OWN = 7'h5A;
   localparam logic [7:0] WLO = 8'd3;
   localparam logic [7:0] WHI = 8'd7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_sda_low = 1'b0;
   logic m_scl_low = 1'b0;
   logic sda_oe, note_stb;
   logic [7:0] note_addr, note_data;
   logic sda_line, scl_line;

   assign sda_line = ~(m_sda_low | sda_oe);
   assign scl_line = ~m_scl_low;

   always #10 clk = ~clk;

   i2c_regfile_target #(.MEM_BYTES(MB)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .sda_oe(sda_oe), .own_addr(OWN), .watch_lo(WLO), .watch_hi(WHI),
      .note_stb(note_stb), .note_addr(note_addr), .note_data(note_data)
   );

   int checks = 0;
   int errors = 0;
   int n_cnt = 0;
   logic [7:0] n_addr = '0, n_data = '0;
   logic [7:0] mdl [MB];

   always @(posedge clk) begin
      if (note_stb) begin
         n_cnt  <= n_cnt + 1;
         n_addr <= note_addr;
         n_data <= note_data;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic m_start();
      m_sda_low = 1'b0; wq();
      m_scl_low = 1'b0; wq();
      m_sda_low = 1'b1; wq();
      m_scl_low = 1'b1; wq();
   endtask

   task automatic m_stop();
      m_sda_low = 1'b1; wq();
      m_scl_low = 1'b0; wq();
      m_sda_low = 1'b0; wq();
   endtask

   task automatic put_bit(input bit b);
      m_sda_low = ~b; wq();
      m_scl_low = 1'b0; wq(); wq();
      m_scl_low = 1'b1; wq();
   endtask

   task automatic get_bit(output bit b);
      m_sda_low = 1'b0; wq();
      m_scl_low = 1'b0; wq();
      b = sda_line; wq();
      m_scl_low = 1'b1; wq();
   endtask

   task automatic write_byte(input logic [7:0] v, output bit ack);
      bit b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      ack = !b;
   endtask

   task automatic read_byte(output logic [7:0] v, input bit ack);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(!ack);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      bit ack;
      logic [7:0] v;
      int exp_n;
      for (int i = 0; i < MB; i++) mdl[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1: reset state at the ports, then array byte 0 through a read
      chk(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
      chk(note_stb == 1'b0, "R1", "note_stb after reset", note_stb, 0);
      m_start();
      write_byte({OWN, 1'b1}, ack);
      chk(ack, "R1", "read address ack", ack, 1);
      read_byte(v, 1'b0);
      chk(v == 8'h00, "R1", "byte at reset pointer", v, 0);
      m_stop();

      // R2: sweep every write-direction address
      for (int a = 0; a < 128; a++) begin
         m_start();
         write_byte({7'(a), 1'b0}, ack);
         chk(ack == (a == int'(OWN)), "R2", $sformatf("ack for address %0h", a),
             ack, a == int'(OWN));
         m_stop();
      end

      // R3, R4, R7, R9: pointer byte 0x15 -> 5, then 20 stored bytes wrap
      exp_n = n_cnt;
      m_start();
      write_byte({OWN, 1'b0}, ack);
      write_byte(8'h15, ack);
      chk(ack, "R9", "pointer byte ack", ack, 1);
      chk(n_cnt == exp_n, "R3", "no strobe on pointer byte", n_cnt, exp_n);
      for (int i = 0; i < 20; i++) begin
         automatic int a = (5 + i) % MB;
         automatic logic [7:0] d = 8'(8'hA0 + i * 7);
         write_byte(d, ack);
         chk(ack, "R9", "data byte ack", ack, 1);
         mdl[a] = d;
         if (a >= int'(WLO) && a <= int'(WHI)) begin
            exp_n++;
            chk(n_addr == 8'(a), "R7", "note_addr", n_addr, a);
            chk(n_data == d, "R7", "note_data", n_data, d);
         end
         chk(n_cnt == exp_n, "R7", "strobe count", n_cnt, exp_n);
      end
      m_stop();

      // R2: unmatched address then data byte: no ack, nothing stored
      m_start();
      write_byte({OWN ^ 7'h01, 1'b0}, ack);
      chk(!ack, "R2", "foreign address ack", ack, 0);
      write_byte(8'h04, ack);
      chk(!ack, "R2", "byte after foreign address", ack, 0);
      write_byte(8'hEE, ack);
      chk(!ack, "R2", "second byte after foreign address", ack, 0);
      chk(n_cnt == exp_n, "R2", "no strobe after foreign address", n_cnt, exp_n);
      m_stop();

      // R5: pointer 0, repeated START read of MB+2 bytes wraps
      m_start();
      write_byte({OWN, 1'b0}, ack);
      write_byte(8'h00, ack);
      m_start();
      write_byte({OWN, 1'b1}, ack);
      for (int i = 0; i < MB + 2; i++) begin
         read_byte(v, i != MB + 1);
         chk(v == mdl[i % MB], "R5", $sformatf("read byte %0d", i), v, mdl[i % MB]);
      end
      m_stop();

      // R6: pointer to 9, bare write address cancelled by STOP
      m_start();
      write_byte({OWN, 1'b0}, ack);
      write_byte(8'h09, ack);
      m_stop();
      m_start();
      write_byte({OWN, 1'b0}, ack);
      m_stop();
      m_start();
      write_byte({OWN, 1'b1}, ack);
      read_byte(v, 1'b0);
      chk(v == mdl[9], "R6", "pointer kept over STOP", v, mdl[9]);
      m_stop();
      // R6: bare write address cancelled by read-direction repeated START
      m_start();
      write_byte({OWN, 1'b0}, ack);
      m_start();
      write_byte({OWN, 1'b1}, ack);
      read_byte(v, 1'b0);
      chk(v == mdl[10], "R6", "pointer kept over repeated START", v, mdl[10]);

      // R8: after NACK the target must not drive SDA
      for (int i = 0; i < 9; i++) begin
         bit b;
         get_bit(b);
         chk(b == 1'b1 && sda_oe == 1'b0, "R8", "SDA released after NACK", b, 1);
      end
      m_stop();
      m_start();
      write_byte({OWN, 1'b1}, ack);
      chk(ack, "R8", "new START served", ack, 1);
      read_byte(v, 1'b0);
      chk(v == mdl[11], "R8", "read after new START", v, mdl[11]);
      m_stop();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule